// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a small 32-bit processor core. It runs five instruction kinds: word load, word store, branch-on-equal, register-to-register arithmetic and logic, and an absolute jump. Each instruction is spread over several clock cycles, so one adder/logic unit and one memory port serve every step. Holding registers carry values from one cycle to the next: the instruction word, the two operands, the arithmetic result and the loaded data word. A finite-state controller steps through the phases. Fetch and decode are shared by every instruction. After them the path splits by opcode, and each instruction takes only the cycles it needs.

Instructions and data share one memory. The memory sees an address, write data and a write strobe, and answers with read data in the same cycle. The core captures that data at the next rising edge. The memory must answer in every cycle and cannot stall the core. There is no valid/ready pairing on this port, so back-pressure is not possible. A system that needs wait states has to gate the clock or use a different front end.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is set to 0 and the controller returns to the fetch phase. In the first cycle after reset, `mem_addr` is 0 and `mem_we` is 0.
- R2: Every instruction begins with a fetch cycle and then a decode cycle. The fetch cycle reads the word at the program counter and adds 4 to the program counter. Total length in cycles: branch 3, jump 3, register operation 4, store 4, load 5, unrecognised opcode 2.
- R3: A load (opcode 0x23; base register in bits 25:21, destination in bits 20:16, signed offset in bits 15:0) reads memory at base + offset in its fourth cycle. It writes that word to the destination register in its fifth cycle.
- R4: A store (opcode 0x2B; same field layout as a load, with bits 20:16 naming the data register) drives `mem_we` high for exactly one cycle, its fourth. In that cycle `mem_addr` is base + offset and `mem_wdata` is the value of the data register. The next cycle is a fetch.
- R5: A register operation (opcode 0x00; sources in bits 25:21 and 20:16, destination in bits 15:11, function code in bits 5:0) computes add 0x20, subtract 0x22, AND 0x24, OR 0x25 or signed set-less-than 0x2A. It writes the result to the destination in its fourth cycle.
- R6: A branch (opcode 0x04) compares the registers named in bits 25:21 and 20:16. If they are equal, the program counter becomes (branch address + 4) + (signed bits 15:0 × 4), and negative offsets are included. If they differ, execution continues at branch address + 4.
- R7: A jump (opcode 0x02) loads the program counter with bits 31:28 of (jump address + 4), followed by bits 25:0 of the instruction, followed by two zero bits.
- R8: Register 0 always reads as zero. A write that names register 0 has no effect.
- R9: Any other opcode changes no register and no memory location. The next fetch is at its address + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address to memory: the program counter during fetch, the computed address during data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe; high for one cycle per store |
| mem_rdata | input | 32 | Read data for `mem_addr`, valid in the same cycle |

## Verification
The case hardest to reach from the ports is a taken branch with a negative offset that lands on code which has already run. Only a loop of stores can show it, together with a counter that reaches zero through a subtraction and takes the forward exit. The test program loads a count, decrements it and stores it on each pass, then branches back with offset −4 until it leaves through a forward branch. Each of those stores is checked for value, address and exact cycle. A jump skips over a store that must never happen, and an unrecognised word sits in the instruction stream. A write to register 0 is followed by a store of register 0.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_JMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDMEM, S_LDWB,
    S_STMEM, S_EXEC, S_RWB, S_BRANCH, S_JUMP
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_t;

  typedef enum logic [1:0] {
    BSRC_REG, BSRC_FOUR, BSRC_IMM, BSRC_BOFS
  } bsrc_t;

  typedef enum logic [1:0] {
    PCS_ALU, PCS_TARGET, PCS_JUMP
  } pcsrc_t;

  typedef struct packed {
    logic    addr_alu;   // memory address from result register
    logic    mem_we;
    logic    ir_we;
    logic    mdr_we;
    logic    pc_we;      // unconditional program counter update
    logic    pc_beq;     // update only on ALU zero
    pcsrc_t  pc_src;
    logic    a_reg;      // ALU A from operand register, else PC
    bsrc_t   b_src;
    alu_op_t alu_op;
    logic    res_we;
    logic    rf_we;
    logic    dst_rd;     // destination bits 15:11, else 20:16
    logic    wb_mem;     // write back loaded word, else result
  } ctl_t;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);

  logic [NREG*DW-1:0] flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign flat[DW-1:0] = '0;
    end else begin : g_live
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (we && wa == AW'(i)) q <= wd;
      end
      assign flat[i*DW +: DW] = q;
    end
  end

  assign rd1 = flat[ra1*DW +: DW];
  assign rd2 = flat[ra2*DW +: DW];

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_t       op,
  output logic [DW-1:0] y,
  output logic          zero
);

  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output state_t     state,
  output ctl_t       ctl
);

  state_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end

  always_comb begin
    nxt = S_FETCH;
    unique case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OP_LOAD, OP_STOR: nxt = S_ADDR;
          OP_REG:           nxt = S_EXEC;
          OP_BEQ:           nxt = S_BRANCH;
          OP_JMP:           nxt = S_JUMP;
          default:          nxt = S_FETCH;
        endcase
      end
      S_ADDR:   nxt = (opcode == OP_LOAD) ? S_LDMEM : S_STMEM;
      S_LDMEM:  nxt = S_LDWB;
      S_EXEC:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end

  alu_op_t fn_op;
  always_comb begin
    unique case (funct)
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: fn_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.alu_op = ALU_ADD;
    ctl.b_src  = BSRC_REG;
    ctl.pc_src = PCS_ALU;
    unique case (state)
      S_FETCH: begin
        ctl.ir_we = 1'b1;
        ctl.pc_we = 1'b1;
        ctl.b_src = BSRC_FOUR;
      end
      S_DECODE: begin
        ctl.b_src  = BSRC_BOFS;
        ctl.res_we = 1'b1;
      end
      S_ADDR: begin
        ctl.a_reg  = 1'b1;
        ctl.b_src  = BSRC_IMM;
        ctl.res_we = 1'b1;
      end
      S_LDMEM: begin
        ctl.addr_alu = 1'b1;
        ctl.mdr_we   = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_mem = 1'b1;
      end
      S_STMEM: begin
        ctl.addr_alu = 1'b1;
        ctl.mem_we   = 1'b1;
      end
      S_EXEC: begin
        ctl.a_reg  = 1'b1;
        ctl.alu_op = fn_op;
        ctl.res_we = 1'b1;
      end
      S_RWB: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = 1'b1;
      end
      S_BRANCH: begin
        ctl.a_reg  = 1'b1;
        ctl.alu_op = ALU_SUB;
        ctl.pc_beq = 1'b1;
        ctl.pc_src = PCS_TARGET;
      end
      S_JUMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = PCS_JUMP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata
);

  state_t          state;
  ctl_t            ctl;
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
  logic [XLEN-1:0] rf_rd1, rf_rd2, alu_a, alu_b, alu_y, imm_sx, pc_nxt;
  logic            alu_zero;

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (ir_q[31:26]),
    .funct  (ir_q[5:0]),
    .state  (state),
    .ctl    (ctl)
  );

  mc_regfile #(.DW(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .ra1 (ir_q[21 +: RAW]),
    .ra2 (ir_q[16 +: RAW]),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2),
    .we  (ctl.rf_we),
    .wa  (ctl.dst_rd ? ir_q[11 +: RAW] : ir_q[16 +: RAW]),
    .wd  (ctl.wb_mem ? mdr_q : res_q)
  );

  assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign alu_a  = ctl.a_reg ? a_q : pc_q;

  always_comb begin
    unique case (ctl.b_src)
      BSRC_FOUR: alu_b = XLEN'(4);
      BSRC_IMM:  alu_b = imm_sx;
      BSRC_BOFS: alu_b = {imm_sx[XLEN-3:0], 2'b00};
      default:   alu_b = b_q;
    endcase
  end

  mc_alu #(.DW(XLEN)) u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    unique case (ctl.pc_src)
      PCS_TARGET: pc_nxt = res_q;
      PCS_JUMP:   pc_nxt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
      default:    pc_nxt = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (ctl.pc_we || (ctl.pc_beq && alu_zero)) pc_q <= pc_nxt;
      if (ctl.ir_we)  ir_q  <= mem_rdata;
      if (ctl.mdr_we) mdr_q <= mem_rdata;
      if (ctl.res_we) res_q <= alu_y;
      a_q <= rf_rd1;
      b_q <= rf_rd2;
    end
  end

  assign mem_addr  = ctl.addr_alu ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input state_t          st,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] res,
  input logic [XLEN-1:0] opa,
  input logic [XLEN-1:0] opb,
  input logic [5:0]      opc,
  input logic            we
);

  logic known_op;
  assign known_op = (opc == OP_REG) || (opc == OP_LOAD) || (opc == OP_STOR) ||
                    (opc == OP_BEQ) || (opc == OP_JMP);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc == '0 && st == S_FETCH));

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (pc == $past(pc) + XLEN'(4) && st == S_DECODE));

  a_r4_store_ends: assert property (@(posedge clk) disable iff (rst)
    we |=> (st == S_FETCH && !we));

  a_r6_taken: assert property (@(posedge clk) disable iff (rst)
    (st == S_BRANCH && opa == opb) |=> (pc == $past(res)));

  a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
    (st == S_BRANCH && opa != opb) |=> $stable(pc));

  a_r9_unknown_op: assert property (@(posedge clk) disable iff (rst)
    (st == S_DECODE && !known_op) |=> (st == S_FETCH && $stable(pc)));

endmodule

bind mc_core mc_core_chk u_chk (
  .clk (clk),
  .rst (rst),
  .st  (state),
  .pc  (pc_q),
  .res (res_q),
  .opa (a_q),
  .opb (b_q),
  .opc (ir_q[31:26]),
  .we  (mem_we)
);

// File: tb/mc_core_test.sv
`timescale 1ns/1ps
module mc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  always #4 clk = ~clk;

  mc_core uut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
  );

  logic [31:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  int n_chk = 0, n_bad = 0, cyc = 0, end_cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'h02, 26'(word)};
  endfunction

  typedef struct { int cy; logic [31:0] addr; logic [31:0] data; } exp_t;
  exp_t sb[$];

  // driver: instruction-level reference walks the program and queues stores
  logic [31:0] mm [0:255];
  task automatic push_expected();
    logic [31:0] rf [0:31];
    logic [31:0] pc, npc, ins, simm, ea, res, tgt;
    int c, len;
    exp_t e;
    for (int i = 0; i < 32; i++) rf[i] = '0;
    pc = 0; c = 0;
    for (int n = 0; n < 500; n++) begin
      ins  = mm[pc[9:2]];
      simm = {{16{ins[15]}}, ins[15:0]};
      npc  = pc + 4;
      ea   = rf[ins[25:21]] + simm;
      len  = 2;
      case (ins[31:26])
        6'h00: begin
          case (ins[5:0])
            6'h22:   res = rf[ins[25:21]] - rf[ins[20:16]];
            6'h24:   res = rf[ins[25:21]] & rf[ins[20:16]];
            6'h25:   res = rf[ins[25:21]] | rf[ins[20:16]];
            6'h2A:   res = {31'd0, $signed(rf[ins[25:21]]) < $signed(rf[ins[20:16]])};
            default: res = rf[ins[25:21]] + rf[ins[20:16]];
          endcase
          if (ins[15:11] != 0) rf[ins[15:11]] = res;
          len = 4;
        end
        6'h23: begin
          if (ins[20:16] != 0) rf[ins[20:16]] = mm[ea[9:2]];
          len = 5;
        end
        6'h2B: begin
          mm[ea[9:2]] = rf[ins[20:16]];
          e.cy = c + 3; e.addr = ea; e.data = rf[ins[20:16]];
          sb.push_back(e);
          len = 4;
        end
        6'h04: begin
          if (rf[ins[25:21]] == rf[ins[20:16]]) npc = npc + {simm[29:0], 2'b00};
          len = 3;
        end
        6'h02: begin
          tgt = {npc[31:28], ins[25:0], 2'b00};
          if (tgt == pc) begin end_cyc = c; break; end
          npc = tgt;
          len = 3;
        end
        default: len = 2;
      endcase
      c += len;
      pc = npc;
    end
  endtask

  // monitor: every store leaving the core is matched against the queue
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4 unexpected store", mem_addr, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(mem_addr == e.addr, "R4 store address", mem_addr, e.addr);
        check(mem_wdata == e.data, "R4 store data", mem_wdata, e.data);
        check(cyc == e.cy, "R2/R9 store cycle", 32'(cyc), 32'(e.cy));
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0]  = enc_i(6'h23, 0, 1, 16'h0200);
    mem[1]  = enc_i(6'h23, 0, 2, 16'h0204);
    mem[2]  = enc_r(1, 2, 3, 6'h20);
    mem[3]  = enc_i(6'h2B, 0, 3, 16'h0300);
    mem[4]  = enc_r(1, 2, 4, 6'h22);
    mem[5]  = enc_i(6'h2B, 0, 4, 16'h0304);
    mem[6]  = enc_r(1, 2, 5, 6'h24);
    mem[7]  = enc_r(1, 2, 6, 6'h25);
    mem[8]  = enc_i(6'h2B, 0, 5, 16'h0308);
    mem[9]  = enc_i(6'h2B, 0, 6, 16'h030C);
    mem[10] = enc_r(2, 1, 7, 6'h2A);
    mem[11] = enc_r(1, 2, 8, 6'h2A);
    mem[12] = enc_i(6'h2B, 0, 7, 16'h0310);
    mem[13] = enc_i(6'h2B, 0, 8, 16'h0314);
    mem[14] = enc_r(1, 1, 0, 6'h20);
    mem[15] = enc_i(6'h2B, 0, 0, 16'h0318);
    mem[16] = 32'hFC00_0000;
    mem[17] = enc_i(6'h04, 1, 2, 16'd5);
    mem[18] = enc_i(6'h23, 0, 9, 16'h0208);
    mem[19] = enc_i(6'h23, 0, 10, 16'h020C);
    mem[20] = enc_r(9, 10, 9, 6'h22);
    mem[21] = enc_i(6'h2B, 0, 9, 16'h031C);
    mem[22] = enc_i(6'h04, 9, 0, 16'd1);
    mem[23] = enc_i(6'h04, 0, 0, 16'hFFFC);
    mem[24] = enc_j(26);
    mem[25] = enc_i(6'h2B, 0, 1, 16'h0320);
    mem[26] = enc_i(6'h2B, 0, 10, 16'h0324);
    mem[27] = enc_j(27);
    mem[128] = 32'd7;
    mem[129] = 32'hFFFF_FFFD;
    mem[130] = 32'd3;
    mem[131] = 32'd1;
    mem[200] = 32'hDEAD_BEEF;
    for (int i = 0; i < 256; i++) mm[i] = mem[i];
    push_expected();

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_we == 1'b0, "R1 write strobe in reset", 32'(mem_we), 32'd0);
    check(mem_addr == 32'd0, "R1 fetch address in reset", mem_addr, 32'd0);
    rst = 1'b0;
    check(mem_addr == 32'd0, "R1 first fetch address", mem_addr, 32'd0);

    while (cyc < end_cyc + 8) @(negedge clk);

    check(sb.size() == 0, "R2 stores outstanding", 32'(sb.size()), 32'd0);
    check(mem[192] == 32'd4,         "R5 add",            mem[192], 32'd4);
    check(mem[193] == 32'd10,        "R5 sub",            mem[193], 32'd10);
    check(mem[194] == 32'd5,         "R5 and",            mem[194], 32'd5);
    check(mem[195] == 32'hFFFF_FFFF, "R5 or",             mem[195], 32'hFFFF_FFFF);
    check(mem[196] == 32'd1,         "R5 slt true",       mem[196], 32'd1);
    check(mem[197] == 32'd0,         "R5 slt false",      mem[197], 32'd0);
    check(mem[198] == 32'd0,         "R8 register zero",  mem[198], 32'd0);
    check(mem[199] == 32'd0,         "R6 loop count",     mem[199], 32'd0);
    check(mem[200] == 32'hDEAD_BEEF, "R7 skipped store",  mem[200], 32'hDEAD_BEEF);
    check(mem[201] == 32'd1,         "R3 loaded value",   mem[201], 32'd1);
    check(mem[16] == 32'hFC00_0000,  "R9 no side effect", mem[16], 32'hFC00_0000);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, end_cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule